// File: doc/BRIEF.md
# Strobe-Decoded Nibble Register File

This block is a bank of thirteen control registers, numbered 0 to 12, that a host loads over a 4-bit bus using two active-low command lines. The two lines are decoded into four commands: idle read-back, address capture, data nibble write and pattern strobe. A register write takes several phases. The host first captures an address. It then writes the low nibble and then the high nibble of the selected register. Every register value is exported on a flat vector to the converter and display logic next to the block.

The command lines and the bus pass through two-flop synchronisers. A command takes effect once, on the first cycle in which a new command level is seen. The pattern strobe never touches a register. It is passed to the display logic as a start pulse and an active level. While the display logic raises its frame hold input, address and data commands are dropped and only the pattern strobe is acted on.

Top module: `strobe_nibble_regs`

## Requirements
- R1: After reset every register holds zero, the nibble pointer and address are zero, the output enable is high with both lines high, and pattern outputs are low.
- R2: With line A low and line B high (address command), the bus value becomes the register address when it is 0 to 12.
- R3: An address command carrying 13, 14 or 15 is ignored: the address and the nibble pointer keep their previous values.
- R4: With line A high and line B low (data command), the bus nibble is written into the addressed register: the first write into bits 3:0, the next into bits 7:4, and the one after that wraps back to bits 3:0.
- R5: An address command returns the nibble pointer to the low nibble (bits 3:0).
- R6: With both lines high the output enable is high and the bus output carries the nibble of the addressed register that the nibble pointer selects. With any other command the output enable is low and the bus output is zero.
- R7: Registers 8 to 12 read back as zero, while their written values still appear on the export vector.
- R8: With both lines low (pattern command), the pattern active output is high for as long as that command lasts, one single-cycle start pulse is issued on entry, and no register changes.
- R9: While frame hold is high, address and data commands have no effect, and the pattern command is still acted on.
- R10: A command held for many cycles acts once; a data command held low writes exactly one nibble.
- R11: Register k is exported on bits k*8+7 down to k*8 of the export vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_line_a_n | input | 1 | Command line A, active low |
| host_line_b_n | input | 1 | Command line B, active low |
| host_nib_in | input | 4 | Host bus value for an address or a data nibble |
| host_nib_out | output | 4 | Read-back nibble |
| host_nib_oe | output | 1 | High when the block drives the read-back nibble |
| frame_hold | input | 1 | From display logic: blocks address and data commands |
| pat_start | output | 1 | One-cycle pulse when a pattern command begins |
| pat_active | output | 1 | High while the pattern command lasts |
| reg_flat | output | 104 | All register contents, register k at bits k*8 upward |

## Verification
The hardest state to reach from the ports is a nibble pointer left at the high nibble of one register when the host switches address or issues an out-of-range address. Only the pointer decides which half the next write lands in. The stimulus writes a single nibble and then re-addresses. It also sends an illegal address between writes. It then shows the pointer's position through the read-back nibble and through the half of the register that the following write changes. Frame hold is raised across whole command sequences, so a dropped write and an accepted pattern strobe are seen in the same window.

// File: rtl/strobe_nibble_regs.sv
module strobe_nibble_regs #(
  parameter int NREG       = 13,
  parameter int DW         = 8,
  parameter int READ_LIMIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_line_a_n,
  input  logic               host_line_b_n,
  input  logic [3:0]         host_nib_in,
  output logic [3:0]         host_nib_out,
  output logic               host_nib_oe,
  input  logic               frame_hold,
  output logic               pat_start,
  output logic               pat_active,
  output logic [NREG*DW-1:0] reg_flat
);
  localparam int NIBS = DW / 4;
  localparam int PW   = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam int AW   = 4;

  localparam logic [1:0] CMD_READ = 2'b11;
  localparam logic [1:0] CMD_ADDR = 2'b01;
  localparam logic [1:0] CMD_DATA = 2'b10;
  localparam logic [1:0] CMD_PAT  = 2'b00;

  logic [1:0]    a_sync, b_sync;
  logic [3:0]    bus_s1, bus_s2;
  logic [1:0]    cmd, cmd_q;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] nib_q;
  logic [DW-1:0] regs [NREG];
  logic          new_cmd;
  logic          addr_ok;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= 2'b11;
      b_sync <= 2'b11;
      bus_s1 <= '0;
      bus_s2 <= '0;
    end else begin
      a_sync <= {a_sync[0], host_line_a_n};
      b_sync <= {b_sync[0], host_line_b_n};
      bus_s1 <= host_nib_in;
      bus_s2 <= bus_s1;
    end
  end

  assign cmd     = {a_sync[1], b_sync[1]};
  assign new_cmd = (cmd != cmd_q);
  assign addr_ok = (int'(bus_s2) < NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_READ;
      addr_q    <= '0;
      nib_q     <= '0;
      pat_start <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else begin
      cmd_q     <= cmd;
      pat_start <= new_cmd && (cmd == CMD_PAT);
      if (new_cmd && !frame_hold) begin
        if (cmd == CMD_ADDR && addr_ok) begin
          addr_q <= bus_s2;
          nib_q  <= '0;
        end else if (cmd == CMD_DATA) begin
          regs[addr_q][{nib_q, 2'b00} +: 4] <= bus_s2;
          nib_q <= (nib_q == PW'(NIBS - 1)) ? '0 : nib_q + 1'b1;
        end
      end
    end
  end

  assign rd_word      = regs[addr_q];
  assign host_nib_oe  = (cmd == CMD_READ);
  assign host_nib_out = (host_nib_oe && int'(addr_q) < READ_LIMIT)
                        ? rd_word[{nib_q, 2'b00} +: 4] : 4'h0;
  assign pat_active   = (cmd == CMD_PAT);

  for (genvar g = 0; g < NREG; g++) begin : g_export
    assign reg_flat[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/strobe_nibble_regs_chk.sv
module strobe_nibble_regs_chk #(
  parameter int NREG       = 13,
  parameter int DW         = 8,
  parameter int READ_LIMIT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_hold,
  input logic               host_nib_oe,
  input logic [3:0]         host_nib_out,
  input logic               pat_start,
  input logic               pat_active,
  input logic [NREG*DW-1:0] reg_flat,
  input logic [3:0]         addr_q
);
  AST_PAT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |=> !pat_start); // R8
  AST_PAT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pat_active |=> $stable(reg_flat)); // R8
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hold |=> $stable(reg_flat)); // R9
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr_q) < NREG); // R3
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !host_nib_oe |-> host_nib_out == 4'h0); // R6
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr_q) >= READ_LIMIT) |-> host_nib_out == 4'h0); // R7
  AST_OE_PAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_nib_oe && pat_active)); // R6
endmodule

bind strobe_nibble_regs strobe_nibble_regs_chk #(
  .NREG(NREG), .DW(DW), .READ_LIMIT(READ_LIMIT)
) chk (
  .clk(clk), .rst_n(rst_n), .frame_hold(frame_hold),
  .host_nib_oe(host_nib_oe), .host_nib_out(host_nib_out),
  .pat_start(pat_start), .pat_active(pat_active),
  .reg_flat(reg_flat), .addr_q(addr_q)
);

// File: tb/strobe_nibble_regs_test.sv
module strobe_nibble_regs_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         la = 1, lb = 1;
  logic [3:0]   nib_in = 0;
  logic         frame_hold = 0;
  logic [3:0]   nib_out;
  logic         nib_oe, pat_start, pat_active;
  logic [103:0] reg_flat;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  strobe_nibble_regs uut (
    .clk(clk), .rst_n(rst_n), .host_line_a_n(la), .host_line_b_n(lb),
    .host_nib_in(nib_in), .host_nib_out(nib_out), .host_nib_oe(nib_oe),
    .frame_hold(frame_hold), .pat_start(pat_start), .pat_active(pat_active),
    .reg_flat(reg_flat)
  );

  always @(negedge clk) if (pat_start) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic phase(input logic a, input logic b, input logic [3:0] d, input int hold = 6);
    @(negedge clk); la = a; lb = b; nib_in = d;
    repeat (hold) @(negedge clk);
    la = 1; lb = 1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] rg(input int k);
    return reg_flat[k*8 +: 8];
  endfunction

  task automatic write_reg(input int k, input logic [7:0] v);
    phase(0, 1, 4'(k));
    phase(1, 0, v[3:0]);
    phase(1, 0, v[7:4]);
  endtask

  task automatic t_reset;
    check(reg_flat == '0, "R1 regs", 0, 0);
    check(nib_oe == 1, "R1 oe", int'(nib_oe), 1);
    check(nib_out == 0, "R1 out", int'(nib_out), 0);
    check(!pat_active && !pat_start, "R1 pat", int'(pat_active), 0);
  endtask

  task automatic t_write_read;
    write_reg(3, 8'hA5);
    check(rg(3) == 8'hA5, "R4 R11 reg3", int'(rg(3)), 'hA5);
    phase(0, 1, 4'd3);
    check(nib_out == 4'h5, "R5 R6 low nibble", int'(nib_out), 5);
    check(nib_oe == 1, "R6 oe idle", int'(nib_oe), 1);
    phase(1, 0, 4'h5);
    check(nib_out == 4'hA, "R6 high nibble", int'(nib_out), 'hA);
    write_reg(11, 8'h96);
    check(rg(11) == 8'h96, "R11 reg11", int'(rg(11)), 'h96);
  endtask

  task automatic t_wrap;
    phase(0, 1, 4'd0);
    phase(1, 0, 4'h1);
    phase(1, 0, 4'h2);
    phase(1, 0, 4'h3);
    check(rg(0) == 8'h23, "R4 wrap", int'(rg(0)), 'h23);
  endtask

  task automatic t_upper;
    write_reg(12, 8'h3C);
    write_reg(8, 8'h7E);
    check(rg(12) == 8'h3C, "R7 reg12 export", int'(rg(12)), 'h3C);
    check(rg(8) == 8'h7E, "R7 reg8 export", int'(rg(8)), 'h7E);
    phase(0, 1, 4'd12);
    check(nib_out == 0, "R7 reg12 read", int'(nib_out), 0);
    phase(0, 1, 4'd8);
    check(nib_out == 0, "R7 reg8 read", int'(nib_out), 0);
    phase(0, 1, 4'd7);
    phase(1, 0, 4'h4);
    check(nib_out == 0 && rg(7) == 8'h04, "R2 reg7", int'(rg(7)), 4);
  endtask

  task automatic t_bad_addr;
    write_reg(2, 8'h77);
    phase(0, 1, 4'd2);
    phase(0, 1, 4'd14);
    check(nib_out == 4'h7, "R3 addr kept", int'(nib_out), 7);
    phase(1, 0, 4'h9);
    check(rg(2) == 8'h79, "R3 pointer kept", int'(rg(2)), 'h79);
    phase(0, 1, 4'd15);
    phase(1, 0, 4'h1);
    check(rg(2) == 8'h19, "R3 addr15 ignored", int'(rg(2)), 'h19);
  endtask

  task automatic t_long_hold;
    phase(0, 1, 4'd5);
    phase(1, 0, 4'h6, 40);
    check(rg(5) == 8'h06, "R10 one nibble", int'(rg(5)), 6);
  endtask

  task automatic t_addr_reset;
    phase(0, 1, 4'd4);
    phase(1, 0, 4'h1);
    phase(0, 1, 4'd4);
    phase(1, 0, 4'h2);
    check(rg(4) == 8'h02, "R5 pointer reset", int'(rg(4)), 2);
  endtask

  task automatic t_pattern;
    logic [103:0] snap;
    int p0;
    snap = reg_flat; p0 = pulses;
    @(negedge clk); la = 0; lb = 0; nib_in = 4'hF;
    repeat (10) @(negedge clk);
    check(pat_active == 1, "R8 active", int'(pat_active), 1);
    check(nib_oe == 0 && nib_out == 0, "R6 oe off", int'(nib_oe), 0);
    la = 1; lb = 1;
    repeat (6) @(negedge clk);
    check(pulses == p0 + 1, "R8 one pulse", pulses - p0, 1);
    check(pat_active == 0, "R8 released", int'(pat_active), 0);
    check(reg_flat == snap, "R8 no write", 0, 0);
  endtask

  task automatic t_hold;
    logic [103:0] snap;
    int p0;
    phase(0, 1, 4'd6);
    snap = reg_flat; p0 = pulses;
    @(negedge clk); frame_hold = 1;
    phase(1, 0, 4'hD);
    phase(0, 1, 4'd1);
    phase(1, 0, 4'hE);
    phase(0, 0, 4'h0);
    check(reg_flat == snap, "R9 writes dropped", 0, 0);
    check(pulses == p0 + 1, "R9 pattern kept", pulses - p0, 1);
    @(negedge clk); frame_hold = 0;
    phase(1, 0, 4'hB);
    check(rg(6) == 8'h0B && rg(1) == 0, "R9 addr unchanged", int'(rg(6)), 'hB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_write_read;
    t_wrap;
    t_upper;
    t_bad_addr;
    t_long_hold;
    t_addr_reset;
    t_pattern;
    t_hold;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule